// File: doc/BRIEF.md
# Zone-Based Access Permission Checker

This block decides, for every memory access a core issues, whether the access may go ahead. Each request carries the permission bits of the page it targets (an executable bit and a writable bit), a 4-bit zone number taken from the same translation entry, the kind of access, and whether the core is in user or privileged mode. A 32-bit zone register, written by software, holds one 2-bit override field for each of 16 zones. The field picked by the zone number can leave the page bits in force, widen them, or shut the page off for user code. Changing one field therefore changes the rights of every page in that zone at once.

Loads and stores get their verdict in the response: a data-storage fault flag. Instruction fetches never fault in the response. Instead, the verdict is queued as a pending flag that follows the fetched instruction through the pipeline. An instruction-storage fault is raised only when the core reports that the oldest fetched instruction executes. A pipeline flush drops every pending flag, so fetched instructions that are discarded never fault.

Requests arrive on a valid/ready channel and verdicts leave on a second valid/ready channel. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. A verdict is held unchanged while `rsp_valid` is high and `rsp_ready` is low. `req_ready` is low whenever the single response slot cannot be emptied in that cycle. It is also low whenever `DEPTH` fetched instructions are already in flight; this applies to every request kind.

Top module: `zone_guard`

## Requirements
- R1: While `rst_n` is low and after its release, `rsp_valid` and `isi_fault` are 0, no instruction is in flight, and every zone field holds the `RESET_VAL` bits (default 32'h5555_5555, so all zones read 01).
- R2: Zone number n selects bits [2n+1:2n] of the zone register; for example, number 5 selects bits [11:10].
- R3: A field of 01 applies the page bits in both modes. A write to a page with writable bit 0 faults, and a fetch from a page with executable bit 0 is flagged. Reads never fault.
- R4: A field of 00 denies every access kind in user mode. In privileged mode a read is always allowed, and writes and fetches follow the page bits.
- R5: A field of 10 applies the page bits in user mode and allows every access kind in privileged mode.
- R6: A field of 11 allows every access kind in both modes, whatever the page bits.
- R7: Zone numbers at or above `ZONES` act as field 11, and writes to their bits of the zone register have no effect.
- R8: A fetch response always has `rsp_fault` = 0. When `exec_fire` is high at an edge while `flush` is low and at least one fetch is in flight, the oldest flag is consumed. `isi_fault` is then high for exactly the next cycle if that flag was set.
- R9: A `flush` at an edge discards every in-flight flag, including a fetch accepted at that same edge, and overrides `exec_fire`. An `exec_fire` with nothing in flight has no effect.
- R10: A response stays valid with unchanged kind and fault while `rsp_ready` is low. `req_ready` = (`rsp_valid` = 0 or `rsp_ready` = 1) and fewer than `DEPTH` fetches are in flight.
- R11: `req_kind` encoding is 00 read, 01 write, 10 fetch, and 11 is treated as a read. A zone-register write (`zpr_we`) at an edge applies to requests accepted at later edges; a request accepted at the same edge sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| zpr_we | input | 1 | Zone register write strobe |
| zpr_wdata | input | 32 | New zone register value, 2 bits per zone |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| req_user | input | 1 | 1 = user mode, 0 = privileged |
| req_pg_ex | input | 1 | Page executable bit |
| req_pg_wr | input | 1 | Page writable bit |
| req_zsel | input | 4 | Zone number from the translation entry |
| rsp_valid | output | 1 | Verdict valid |
| rsp_ready | input | 1 | Consumer takes the verdict |
| rsp_kind | output | 2 | Kind of the access the verdict belongs to |
| rsp_fault | output | 1 | Data-storage fault (always 0 for fetches) |
| exec_fire | input | 1 | Oldest in-flight instruction executes |
| flush | input | 1 | Discard all in-flight instructions |
| isi_fault | output | 1 | Instruction-storage fault, one-cycle pulse |

## Verification
A request accepted at edge N shows its verdict on the response port right after edge N. An `exec_fire` sampled at edge E produces its `isi_fault` pulse in the cycle after edge E. `req_ready` is combinational on `rsp_ready` and the in-flight count, so it is due in the same cycle the inputs change. The bench drives inputs just after the falling edge, compares `req_ready` 1 ns later, and advances its reference model for the inputs seen at the rising edge. It then compares the registered outputs at the following falling edge. Zone-register writes update the model only after the verdict for that edge's request has been computed, which matches the old-value rule.

// File: rtl/zg_pkg.sv
package zg_pkg;
  localparam int unsigned ZONE_SLOTS = 16;
  localparam int unsigned ZSEL_W     = 4;
  localparam int unsigned ZREG_W     = 2 * ZONE_SLOTS;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_ALTRD = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    ZM_LOCK = 2'b00,  // user locked out, privileged reads always
    ZM_PAGE = 2'b01,  // page bits as given
    ZM_SUPV = 2'b10,  // page bits for user, privileged unrestricted
    ZM_OPEN = 2'b11   // unrestricted
  } zone_mode_e;
endpackage

// File: rtl/zg_zone_regs.sv
module zg_zone_regs
  import zg_pkg::*;
#(
  parameter int unsigned ZONES     = 16,
  parameter logic [31:0] RESET_VAL = 32'h5555_5555
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ZREG_W-1:0] wr_data,
  input  logic [ZSEL_W-1:0] sel,
  output zone_mode_e        mode
);
  logic [1:0] field [ZONE_SLOTS];

  for (genvar i = 0; i < ZONE_SLOTS; i++) begin : g_zone
    if (i < ZONES) begin : g_impl
      logic [1:0] fld_q;
      always_ff @(posedge clk) begin
        if (!rst_n)     fld_q <= RESET_VAL[2*i +: 2];
        else if (wr_en) fld_q <= wr_data[2*i +: 2];
      end
      assign field[i] = fld_q;
    end else begin : g_fixed
      logic unused_bits;
      assign unused_bits = ^wr_data[2*i +: 2];
      assign field[i]    = 2'b11;
    end
  end

  assign mode = zone_mode_e'(field[sel]);
endmodule

// File: rtl/zg_perm.sv
module zg_perm
  import zg_pkg::*;
(
  input  zone_mode_e mode,
  input  acc_kind_e  kind,
  input  logic       user,
  input  logic       pg_ex,
  input  logic       pg_wr,
  output logic       deny
);
  logic may_rd, may_wr, may_ex;

  always_comb begin
    may_rd = 1'b1;
    may_wr = pg_wr;
    may_ex = pg_ex;
    unique case (mode)
      ZM_LOCK: if (user) begin
        may_rd = 1'b0;
        may_wr = 1'b0;
        may_ex = 1'b0;
      end
      ZM_PAGE: ;
      ZM_SUPV: if (!user) begin
        may_wr = 1'b1;
        may_ex = 1'b1;
      end
      ZM_OPEN: begin
        may_wr = 1'b1;
        may_ex = 1'b1;
      end
      default: ;
    endcase
    unique case (kind)
      ACC_WRITE: deny = !may_wr;
      ACC_FETCH: deny = !may_ex;
      default:   deny = !may_rd;
    endcase
  end
endmodule

// File: rtl/zg_pend_queue.sv
module zg_pend_queue #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             push_flag,
  input  logic             pop,
  input  logic             flush,
  output logic [CNT_W-1:0] count,
  output logic             head_flag,
  output logic             full
);
  logic [DEPTH-1:0] flags_q;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full      = (count == CNT_W'(DEPTH));
  assign head_flag = flags_q[rd_ptr];
  assign do_push   = push && !flush;
  assign do_pop    = pop && !flush && (count != '0);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       flags_q <= '0;
    else if (do_push) flags_q[wr_ptr] <= push_flag;
  end
endmodule

// File: rtl/zone_guard.sv
module zone_guard
  import zg_pkg::*;
#(
  parameter int unsigned ZONES     = 16,
  parameter int unsigned DEPTH     = 4,
  parameter logic [31:0] RESET_VAL = 32'h5555_5555,
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        zpr_we,
  input  logic [31:0] zpr_wdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_kind,
  input  logic        req_user,
  input  logic        req_pg_ex,
  input  logic        req_pg_wr,
  input  logic [3:0]  req_zsel,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [1:0]  rsp_kind,
  output logic        rsp_fault,
  input  logic        exec_fire,
  input  logic        flush,
  output logic        isi_fault
);
  zone_mode_e       mode;
  acc_kind_e        kind;
  logic             deny, fire, is_fetch, q_full, q_head;
  logic [CNT_W-1:0] q_cnt;

  assign kind     = acc_kind_e'(req_kind);
  assign is_fetch = (kind == ACC_FETCH);
  assign req_ready = (!rsp_valid || rsp_ready) && !q_full;
  assign fire     = req_valid && req_ready;

  zg_zone_regs #(.ZONES(ZONES), .RESET_VAL(RESET_VAL)) u_zones (
    .clk(clk), .rst_n(rst_n), .wr_en(zpr_we), .wr_data(zpr_wdata),
    .sel(req_zsel), .mode(mode)
  );

  zg_perm u_perm (
    .mode(mode), .kind(kind), .user(req_user),
    .pg_ex(req_pg_ex), .pg_wr(req_pg_wr), .deny(deny)
  );

  zg_pend_queue #(.DEPTH(DEPTH)) u_pend (
    .clk(clk), .rst_n(rst_n), .push(fire && is_fetch), .push_flag(deny),
    .pop(exec_fire), .flush(flush), .count(q_cnt), .head_flag(q_head),
    .full(q_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_kind  <= 2'b00;
      rsp_fault <= 1'b0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_kind  <= req_kind;
      rsp_fault <= deny && !is_fetch;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) isi_fault <= 1'b0;
    else        isi_fault <= exec_fire && !flush && (q_cnt != '0) && q_head;
  end
endmodule

// File: rtl/zone_guard_chk.sv
module zone_guard_chk #(
  parameter int unsigned ZONES = 16,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       req_kind,
  input logic [3:0]       req_zsel,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [1:0]       rsp_kind,
  input logic             rsp_fault,
  input logic             exec_fire,
  input logic             flush,
  input logic             isi_fault,
  input logic [CNT_W-1:0] inflight
);
  // R10: an unconsumed verdict stays put
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_kind) && $stable(rsp_fault));

  // R10: no request taken while DEPTH fetches are in flight
  a_r10_full_block: assert property (@(posedge clk) disable iff (!rst_n)
    inflight == CNT_W'(DEPTH) |-> !req_ready);

  // R8: fetch verdicts never carry a data fault
  a_r8_fetch_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == 2'b10 |-> !rsp_fault);

  // R8: an instruction fault needs an execute with something in flight
  a_r8_isi_cause: assert property (@(posedge clk) disable iff (!rst_n)
    isi_fault |-> $past(exec_fire && !flush && inflight != '0));

  // R9: a flush never yields an instruction fault
  a_r9_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !isi_fault);

  // R7: unimplemented zones never produce a data fault
  a_r7_unimpl_open: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && ({1'b0, req_zsel} >= 5'(ZONES)) && req_kind != 2'b10
    |=> !rsp_fault);
endmodule

bind zone_guard zone_guard_chk #(.ZONES(ZONES), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_kind(req_kind), .req_zsel(req_zsel), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_fault(rsp_fault),
  .exec_fire(exec_fire), .flush(flush), .isi_fault(isi_fault), .inflight(q_cnt)
);

// File: tb/zone_guard_tb.sv
module zone_guard_tb;
  localparam int ZN = 12;
  localparam int DP = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, zpr_we, req_valid, req_ready, req_user, req_pg_ex, req_pg_wr;
  logic rsp_valid, rsp_ready, rsp_fault, exec_fire, flush, isi_fault;
  logic [31:0] zpr_wdata;
  logic [1:0] req_kind, rsp_kind;
  logic [3:0] req_zsel;

  zone_guard #(.ZONES(ZN), .DEPTH(DP)) u_dut (.*);

  int checks = 0, errors = 0, cycles = 0;
  bit [31:0] m_zpr;
  bit m_valid, m_fault, m_isi;
  bit [1:0] m_kind;
  bit q[$];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit ref_deny(bit [1:0] k, bit u, bit ex, bit wr, int z);
    bit [1:0] f;
    bit r_ok, w_ok, x_ok;
    f = (z >= ZN) ? 2'b11 : m_zpr[2*z +: 2];
    if (f == 2'b11 || (f == 2'b10 && !u)) {r_ok, w_ok, x_ok} = 3'b111;
    else if (f == 2'b00 && u)             {r_ok, w_ok, x_ok} = 3'b000;
    else                                  {r_ok, w_ok, x_ok} = {1'b1, wr, ex};
    if (k == 2'b01) return !w_ok;
    if (k == 2'b10) return !x_ok;
    return !r_ok;
  endfunction

  function automatic bit ref_ready();
    return (!m_valid || rsp_ready) && (q.size() < DP);
  endfunction

  // one clock: check ready for current inputs, model the edge, compare outputs
  task automatic tick(string tag);
    bit rdy, fire, d;
    #1;
    rdy = ref_ready();
    chk(req_ready == rdy, "R10", {tag, " req_ready"}, req_ready, rdy);
    @(posedge clk);
    @(negedge clk);
    fire = req_valid && rdy;
    d = ref_deny(req_kind, req_user, req_pg_ex, req_pg_wr, req_zsel);
    m_isi = exec_fire && !flush && q.size() > 0 && q[0];
    if (flush) q.delete();
    else begin
      if (exec_fire && q.size() > 0) void'(q.pop_front());
      if (fire && req_kind == 2'b10) q.push_back(d);
    end
    if (fire) begin
      m_valid = 1'b1;
      m_kind  = req_kind;
      m_fault = d && (req_kind != 2'b10);
    end else if (rsp_ready) m_valid = 1'b0;
    if (zpr_we) m_zpr = zpr_wdata;
    chk(rsp_valid == m_valid, tag, "rsp_valid", rsp_valid, m_valid);
    if (m_valid) begin
      chk(rsp_kind == m_kind, tag, "rsp_kind", rsp_kind, m_kind);
      chk(rsp_fault == m_fault, tag, "rsp_fault", rsp_fault, m_fault);
    end
    chk(isi_fault == m_isi, tag, "isi_fault", isi_fault, m_isi);
  endtask

  task automatic issue(bit [1:0] k, bit u, bit ex, bit wr, int z, string tag);
    req_valid = 1'b1; req_kind = k; req_user = u;
    req_pg_ex = ex; req_pg_wr = wr; req_zsel = 4'(z);
    tick(tag);
    req_valid = 1'b0;
  endtask

  task automatic set_zone(int z, bit [1:0] f);
    bit [31:0] v;
    v = m_zpr;
    v[2*z +: 2] = f;
    zpr_we = 1'b1; zpr_wdata = v;
    tick("R11");
    zpr_we = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog (all R): cycles %0d expected < %0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; zpr_we = 1'b0; zpr_wdata = '0; req_valid = 1'b0;
    req_kind = '0; req_user = 1'b0; req_pg_ex = 1'b0; req_pg_wr = 1'b0;
    req_zsel = '0; rsp_ready = 1'b1; exec_fire = 1'b0; flush = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
    chk(isi_fault == 1'b0, "R1", "isi_fault", isi_fault, 0);
    chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    m_zpr = 32'h5555_5555; m_valid = 0; m_fault = 0; m_isi = 0; m_kind = 0;
    rst_n = 1'b1;
    tick("R1");

    // R3: page bits under field 01 (reset value)
    issue(2'b01, 1, 1, 0, 5, "R3");
    issue(2'b00, 1, 0, 0, 5, "R3");
    issue(2'b01, 1, 1, 1, 5, "R3");
    issue(2'b11, 1, 0, 0, 2, "R11");
    // R2/R6: only zone 5 opened; neighbour 4 unchanged
    set_zone(5, 2'b11);
    issue(2'b01, 1, 0, 0, 5, "R6");
    issue(2'b01, 1, 0, 0, 4, "R2");
    issue(2'b01, 0, 0, 0, 6, "R2");
    // R11: same-edge write and request sees the old field
    zpr_we = 1'b1; zpr_wdata = m_zpr; zpr_wdata[9:8] = 2'b11;
    issue(2'b01, 1, 0, 0, 4, "R11");
    zpr_we = 1'b0;
    issue(2'b01, 1, 0, 0, 4, "R11");
    // R4: locked zone
    set_zone(3, 2'b00);
    issue(2'b00, 1, 1, 1, 3, "R4");
    issue(2'b01, 1, 1, 1, 3, "R4");
    issue(2'b00, 0, 0, 0, 3, "R4");
    issue(2'b01, 0, 0, 0, 3, "R4");
    issue(2'b01, 0, 0, 1, 3, "R4");
    // R5: supervisor-open zone
    set_zone(6, 2'b10);
    issue(2'b01, 1, 0, 0, 6, "R5");
    issue(2'b01, 0, 0, 0, 6, "R5");
    // R7: zones >= ZN are open even after writing zeros to their bits
    zpr_we = 1'b1; zpr_wdata = 32'h0000_0000; tick("R7"); zpr_we = 1'b0;
    issue(2'b00, 1, 0, 0, 13, "R7");
    issue(2'b01, 1, 0, 0, 15, "R7");
    issue(2'b00, 1, 0, 0, 2, "R7");
    // R8: deferred instruction fault
    zpr_we = 1'b1; zpr_wdata = 32'h5555_5555; tick("R8"); zpr_we = 1'b0;
    issue(2'b10, 1, 0, 1, 1, "R8");
    issue(2'b10, 1, 1, 1, 1, "R8");
    exec_fire = 1'b1; tick("R8"); tick("R8"); tick("R8");
    exec_fire = 1'b0; tick("R8");
    // R9: flush discards, same-edge fetch dropped, exec on empty ignored
    issue(2'b10, 1, 0, 0, 1, "R9");
    flush = 1'b1;
    issue(2'b10, 1, 0, 0, 1, "R9");
    flush = 1'b0;
    exec_fire = 1'b1; tick("R9"); exec_fire = 1'b0;
    issue(2'b10, 1, 0, 0, 1, "R9");
    flush = 1'b1; exec_fire = 1'b1; tick("R9");
    flush = 1'b0; exec_fire = 1'b0; tick("R9");
    // R10: back-pressure and in-flight limit
    rsp_ready = 1'b0;
    issue(2'b01, 1, 0, 0, 1, "R10");
    issue(2'b00, 1, 0, 0, 1, "R10");
    tick("R10");
    rsp_ready = 1'b1;
    for (int i = 0; i < DP + 1; i++) issue(2'b10, 1, i[0], 0, 1, "R10");
    issue(2'b00, 0, 0, 0, 1, "R10");
    exec_fire = 1'b1;
    for (int i = 0; i < DP + 1; i++) tick("R8");
    exec_fire = 1'b0;
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      req_valid = $urandom_range(0, 1) == 1; req_kind = 2'($urandom);
      req_user = 1'($urandom); req_pg_ex = 1'($urandom); req_pg_wr = 1'($urandom);
      req_zsel = 4'($urandom); rsp_ready = $urandom_range(0, 3) != 0;
      exec_fire = $urandom_range(0, 2) == 0; flush = $urandom_range(0, 15) == 0;
      zpr_we = $urandom_range(0, 15) == 0; zpr_wdata = $urandom;
      tick("R2");
    end
    req_valid = 0; zpr_we = 0; flush = 0; exec_fire = 0; rsp_ready = 1;
    tick("R10");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule